// File: doc/BRIEF.md
# Arrival-Order Interrupt Controller

This block gathers sixty-four interrupt request lines from peripherals into a single interrupt output for the processor. Each line has a pending bit and an enable (mask) bit. The output is raised whenever at least one source is both pending and enabled. No source number outranks another. New requests are placed in a small queue of source numbers, and software always sees the oldest waiting source first.

By convention, lines 32 to 63 are free for user-defined peripherals and lines 0 to 31 belong to the system. Within the system range, timers take 16 to 31, GPIO takes 8 to 15 and the serial ports take 0 to 3. Each timer uses a pair of lines: its even line reports a compare event and its odd line reports that the count reached zero. The controller treats every line the same way. Software reads the head register to learn which source to serve. After servicing that source it writes the same number to the clear register, which drops the pending bit and moves the queue forward.

All register accesses use a single-cycle bus. A write takes effect at the clock edge. A read returns data combinationally from the current state.

Top module: `arrival_irq_ctrl`

## Requirements
- R1: After reset the pending bits and mask bits are all zero, the queue is empty, irq_o is low, and reads of the pending words (word 0 and word 1), the mask words (word 2 and word 3) and the head word (word 4) return 0.
- R2: A 0-to-1 change of a request line between two clock edges sets that line's pending bit, and software sees it in the following cycle. A line that simply stays high does not set the bit again after it has been cleared.
- R3: A rising edge on a line whose pending bit is already set is dropped and adds no second queue entry.
- R4: irq_o is high exactly when some source has both its pending bit and its mask bit set. It follows register changes with no added delay.
- R5: A source whose mask bit is clear still becomes pending and still enters the queue in its turn. It does not drive irq_o.
- R6: Word 4 (head) reads with bit 31 set when the queue is non-empty, and bits 5:0 then hold the number of the oldest queued source. When the queue is empty, word 4 reads 0.
- R7: Sources that become pending in the same cycle join the queue in ascending source number.
- R8: A write to word 5 (clear) whose data equals the head source number clears that source's pending bit and removes it from the queue. Any other written value, and any write while the queue is empty, has no effect.
- R9: Writing to word 0 (sources 31:0) or word 1 (sources 63:32) raises each source whose data bit is 1, exactly as a line edge would. Data bits that are 0 leave their sources unchanged.
- R10: Word 2 holds the mask for sources 31:0 and word 3 holds the mask for sources 63:32. Both can be written and read back. Pending word 0 reads sources 31:0 and pending word 1 reads sources 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 64 | Peripheral request lines, edge sensitive |
| reg_addr_i | input | 3 | Register word index |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that request lines are synchronous to clk and stable around the edge. They also assume that reset stays asserted long enough for the first sampled history to be defined. Under these conditions the queue count always equals the number of pending bits, and the head source is always pending. The stimulus changes lines and the bus only on the falling edge. It holds reset for several cycles with all lines low and releases it only then. It drives each edge case (simultaneous rises, a rise on an already pending source, a wrong clear value) separately, so that each check has a single cause.

// File: rtl/arrival_irq_ctrl.sv
module arrival_irq_ctrl #(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int WORDS  = NUM_SRC / DATA_W;
  localparam int A_MASK = WORDS;
  localparam int A_HEAD = 2 * WORDS;
  localparam int A_CLR  = 2 * WORDS + 1;

  logic [NUM_SRC-1:0] pend_q, mask_q, line_q, sw_set, arrive, drop_vec;
  logic [IDX_W-1:0]   fifo_q [NUM_SRC];
  logic [IDX_W:0]     rank   [NUM_SRC];
  logic [IDX_W-1:0]   rd_ptr_q, tail, head_src;
  logic [IDX_W:0]     cnt_q, n_arrive;
  logic               has_head, pop;

  assign has_head = cnt_q != '0;
  assign head_src = fifo_q[rd_ptr_q];
  assign tail     = rd_ptr_q + cnt_q[IDX_W-1:0];
  assign pop      = reg_wr_i && reg_addr_i == ADDR_W'(A_CLR) && has_head
                    && reg_wdata_i == DATA_W'(head_src);
  assign drop_vec = pop ? (NUM_SRC'(1) << head_src) : '0;
  assign irq_o    = |(pend_q & mask_q);
  assign arrive   = ((irq_lines_i & ~line_q) | sw_set) & ~pend_q;

  always_comb begin
    sw_set = '0;
    for (int w = 0; w < WORDS; w++)
      if (reg_wr_i && reg_addr_i == ADDR_W'(w))
        sw_set[w*DATA_W +: DATA_W] = reg_wdata_i;
  end

  always_comb begin
    logic [IDX_W:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      rank[i] = acc;
      acc = acc + (IDX_W+1)'(arrive[i]);
    end
    n_arrive = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mask_q   <= '0;
      line_q   <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      line_q   <= irq_lines_i;
      pend_q   <= (pend_q & ~drop_vec) | arrive;
      rd_ptr_q <= rd_ptr_q + IDX_W'(pop);
      cnt_q    <= cnt_q + n_arrive - (IDX_W+1)'(pop);
      for (int w = 0; w < WORDS; w++)
        if (reg_wr_i && reg_addr_i == ADDR_W'(A_MASK + w))
          mask_q[w*DATA_W +: DATA_W] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++)
      if (arrive[i])
        fifo_q[tail + rank[i][IDX_W-1:0]] <= IDX_W'(i);
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(w))          reg_rdata_o = pend_q[w*DATA_W +: DATA_W];
      if (reg_addr_i == ADDR_W'(A_MASK + w)) reg_rdata_o = mask_q[w*DATA_W +: DATA_W];
    end
    if (reg_addr_i == ADDR_W'(A_HEAD) && has_head) begin
      reg_rdata_o[DATA_W-1]  = 1'b1;
      reg_rdata_o[IDX_W-1:0] = head_src;
    end
  end

  p_count_tracks_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) == $countones(pend_q));

  p_edge_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_lines_i) & ~$past(line_q) & ~$past(pend_q) & ~pend_q) == '0));

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !has_head |-> !irq_o);

  p_head_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    has_head |-> pend_q[head_src]);

  p_bad_clear_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADDR_W'(A_CLR) && !pop) |=> rd_ptr_q == $past(rd_ptr_q));

  p_single_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones($past(pend_q) & ~pend_q) <= 1);
endmodule

// File: tb/test_arrival_irq_ctrl.sv
module test_arrival_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OP_DRIVE = 0, OP_WMASK = 1, OP_WCLR = 2, OP_HEAD = 3,
                         OP_IRQ = 4, OP_PLO = 5, OP_PHI = 6, OP_WPEND = 7,
                         OP_MLO = 8, OP_MHI = 9;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  req;
    logic [63:0] arg;
    logic [31:0] exp;
  } step_t;

  localparam logic [63:0] ONE = 64'd1;
  localparam int NSTEP = 46;
  localparam step_t STEPS [NSTEP] = '{
    '{OP_IRQ,   4'd1,  64'd0, 32'd0},                              // R1
    '{OP_HEAD,  4'd1,  64'd0, 32'd0},                              // R1
    '{OP_PLO,   4'd1,  64'd0, 32'd0},                              // R1
    '{OP_MLO,   4'd1,  64'd0, 32'd0},                              // R1
    '{OP_WMASK, 4'd10, ~64'd0, 32'd0},                             // R10
    '{OP_MLO,   4'd10, 64'd0, 32'hFFFF_FFFF},                      // R10
    '{OP_DRIVE, 4'd2,  ONE << 5, 32'd0},
    '{OP_PLO,   4'd2,  64'd0, 32'h20},                             // R2
    '{OP_IRQ,   4'd4,  64'd0, 32'd1},                              // R4
    '{OP_HEAD,  4'd6,  64'd0, 32'h8000_0005},                      // R6
    '{OP_DRIVE, 4'd7,  (ONE << 5) | (ONE << 40) | (ONE << 2), 32'd0},
    '{OP_PHI,   4'd2,  64'd0, 32'h100},                            // R2
    '{OP_HEAD,  4'd6,  64'd0, 32'h8000_0005},                      // R6
    '{OP_WCLR,  4'd8,  64'd5, 32'd0},
    '{OP_HEAD,  4'd7,  64'd0, 32'h8000_0002},                      // R7
    '{OP_WCLR,  4'd8,  64'd9, 32'd0},
    '{OP_HEAD,  4'd8,  64'd0, 32'h8000_0002},                      // R8
    '{OP_DRIVE, 4'd3,  (ONE << 5) | (ONE << 40), 32'd0},
    '{OP_DRIVE, 4'd3,  (ONE << 5) | (ONE << 40) | (ONE << 2), 32'd0},
    '{OP_WCLR,  4'd8,  64'd2, 32'd0},
    '{OP_HEAD,  4'd3,  64'd0, 32'h8000_0028},                      // R3
    '{OP_WCLR,  4'd8,  64'd40, 32'd0},
    '{OP_HEAD,  4'd3,  64'd0, 32'd0},                              // R3
    '{OP_PLO,   4'd8,  64'd0, 32'd0},                              // R8
    '{OP_IRQ,   4'd4,  64'd0, 32'd0},                              // R4
    '{OP_WMASK, 4'd5,  64'd0, 32'd0},
    '{OP_DRIVE, 4'd5,  ONE << 17, 32'd0},
    '{OP_IRQ,   4'd5,  64'd0, 32'd0},                              // R5
    '{OP_HEAD,  4'd5,  64'd0, 32'h8000_0011},                      // R5
    '{OP_PLO,   4'd5,  64'd0, 32'h0002_0000},                      // R5
    '{OP_WMASK, 4'd4,  ONE << 17, 32'd0},
    '{OP_IRQ,   4'd4,  64'd0, 32'd1},                              // R4
    '{OP_WCLR,  4'd8,  64'd17, 32'd0},
    '{OP_IRQ,   4'd8,  64'd0, 32'd0},                              // R8
    '{OP_PLO,   4'd2,  64'd0, 32'd0},                              // R2 held level
    '{OP_WPEND, 4'd9,  (ONE << 63) | ONE, 32'd0},
    '{OP_HEAD,  4'd9,  64'd0, 32'h8000_0000},                      // R9
    '{OP_PHI,   4'd9,  64'd0, 32'h8000_0000},                      // R9
    '{OP_WCLR,  4'd9,  64'd0, 32'd0},
    '{OP_HEAD,  4'd9,  64'd0, 32'h8000_003F},                      // R9
    '{OP_WCLR,  4'd9,  64'd63, 32'd0},
    '{OP_HEAD,  4'd9,  64'd0, 32'd0},                              // R9
    '{OP_MLO,   4'd10, 64'd0, 32'h0002_0000},                      // R10
    '{OP_MHI,   4'd10, 64'd0, 32'd0},                              // R10
    '{OP_WPEND, 4'd9,  64'd0, 32'd0},
    '{OP_PLO,   4'd9,  64'd0, 32'd0}                               // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  arrival_irq_ctrl i_arrival_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input int req, input logic [31:0] exp);
    addr = a;
    #1 check(req, rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NSTEP; s++) begin
      case (STEPS[s].op)
        OP_DRIVE: begin lines = STEPS[s].arg; @(negedge clk); end
        OP_WMASK: begin wreg(3'd2, STEPS[s].arg[31:0]); wreg(3'd3, STEPS[s].arg[63:32]); end
        OP_WPEND: begin wreg(3'd0, STEPS[s].arg[31:0]); wreg(3'd1, STEPS[s].arg[63:32]); end
        OP_WCLR:  wreg(3'd5, STEPS[s].arg[31:0]);
        OP_HEAD:  rchk(3'd4, int'(STEPS[s].req), STEPS[s].exp);
        OP_PLO:   rchk(3'd0, int'(STEPS[s].req), STEPS[s].exp);
        OP_PHI:   rchk(3'd1, int'(STEPS[s].req), STEPS[s].exp);
        OP_MLO:   rchk(3'd2, int'(STEPS[s].req), STEPS[s].exp);
        OP_MHI:   rchk(3'd3, int'(STEPS[s].req), STEPS[s].exp);
        OP_IRQ:   begin #1 check(int'(STEPS[s].req), {31'd0, irq}, STEPS[s].exp); @(negedge clk); end
        default:  @(negedge clk);
      endcase
    end

    // R1: reset in the middle of activity clears everything
    wreg(3'd2, 32'hFFFF_FFFF);
    lines = 64'd8;
    @(negedge clk);
    rchk(3'd0, 2, 32'h8);
    rst_n = 1'b0;
    lines = '0;
    repeat (2) @(negedge clk);
    #1 check(1, {31'd0, irq}, 32'd0);
    rchk(3'd0, 1, 32'd0);
    rchk(3'd4, 1, 32'd0);
    rchk(3'd2, 1, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: four simultaneous rises spread over both words, served ascending
    wreg(3'd2, 32'hFFFF_FFFF);
    wreg(3'd3, 32'hFFFF_FFFF);
    lines = (ONE << 60) | (ONE << 33) | (ONE << 16) | (ONE << 1);
    @(negedge clk);
    rchk(3'd4, 7, 32'h8000_0001);
    wreg(3'd5, 32'd1);
    rchk(3'd4, 7, 32'h8000_0010);
    wreg(3'd5, 32'd16);
    rchk(3'd4, 7, 32'h8000_0021);
    wreg(3'd5, 32'd33);
    rchk(3'd4, 7, 32'h8000_003C);
    wreg(3'd5, 32'd60);
    rchk(3'd4, 7, 32'd0);
    // R8: clear write with empty queue has no effect on state
    wreg(3'd5, 32'd0);
    rchk(3'd0, 8, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule